// File: doc/BRIEF.md
# Receive Word-to-Nibble Serializer

This block moves receive samples from a wide word-rate path onto a narrow port. Every sample is a twos-complement word of `WORD_W` bits (12 by default). It goes out as two half-width nibbles in consecutive nibble slots, so the port runs at twice the sample rate. A sync line tells the far end which half is on the bus. The upper half is driven while sync is low, and the lower half of the same word follows with sync high. A forwarded port clock goes out with the data. Its polarity can be flipped, and it can be parked low, which also freezes the serializer.

The core clock `clk` runs at twice the nibble rate. Each enabled `clk` cycle toggles the forwarded clock. The nibble bus and sync change only when the forwarded clock makes its inactive transition, so the receiving side always samples a settled value on the active edge. A new sample is taken only when an upper-half slot begins. A sample that arrives at any other time waits in a one-entry holding register. If nothing new is available at the start of an upper-half slot, the previous word is sent again, so the sync pattern never stalls.

Top module: `rx_nibble_serializer`

## Requirements
- R1: While reset is asserted, `nib_out`, `nib_sync` and `port_clk` are all 0.
- R2: When a word is loaded, the next nibble slot drives bits [WORD_W-1:WORD_W/2] of that word with `nib_sync` low.
- R3: The slot after the upper half drives bits [WORD_W/2-1:0] of the same word with `nib_sync` high.
- R4: `nib_out` and `nib_sync` never change at the active edge of `port_clk`. The active edge is rising when `clk_inv`=0 and falling when `clk_inv`=1.
- R5: While `clk_en`=1, `port_clk` toggles on every `clk` cycle. The bus changes in the cycle where `port_clk` becomes equal to `clk_inv`.
- R6: While `clk_en`=0, `port_clk` is held at 0 and `nib_out`/`nib_sync` are frozen. After re-enable, the nibble sequence resumes with the slot that follows the last one sent.
- R7: A word offered outside an upper-half load, including while disabled, is kept in the holding register and sent at the next load. If several words are offered before that load, only the most recent is kept.
- R8: If no word is held or offered at a load, the previous word is sent again.
- R9: After reset, the word on the port is zero until a valid word has been loaded.
- R10: A word offered in the load cycle with the holding register empty goes out directly. Its upper half is present at the active edge two `clk` cycles later. If the holding register is full at that load, the held word goes first and the new word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the nibble rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Runs the forwarded clock and the serializer; 0 parks both |
| clk_inv | input | 1 | Inverts the forwarded clock |
| rx_word | input | WORD_W | Receive sample, twos complement |
| rx_word_vld | input | 1 | Qualifies `rx_word` for one `clk` cycle |
| nib_out | output | WORD_W/2 | Nibble bus |
| nib_sync | output | 1 | Low on the upper half, high on the lower half |
| port_clk | output | 1 | Forwarded nibble clock |

## Verification
The bench builds the block with the defaults: `WORD_W`=12, holding register present, zero reset word. A 6-bit nibble lets table entries such as the most negative and most positive samples and alternating patterns exercise every bit of both halves. With the holding register present, the bench can reach the orderings that depend on it: a word taking the direct path, a held word going out ahead of a word offered at the load, overwrite of a held word, and capture while disabled. Both clock polarities are run so that the edge-placement rule is checked from each side.

// File: rtl/rxser_pkg.sv
package rxser_pkg;
   typedef enum logic {
      SLOT_MSB = 1'b0,
      SLOT_LSB = 1'b1
   } slot_e;
endpackage

// File: rtl/rxser_clkgen.sv
// Forwarded clock generator. The internal level toggles on every enabled
// cycle, and the serializer steps when that level falls. The output is
// registered and polarity-adjusted, so the bus always changes on the
// inactive edge.
module rxser_clkgen (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic inv,
   output logic step,
   output logic port_clk
);
   logic lvl_q;
   logic pclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= 1'b0;
         pclk_q <= 1'b0;
      end else begin
         if (en) lvl_q <= ~lvl_q;
         pclk_q <= en ? (~lvl_q ^ inv) : 1'b0;
      end
   end

   assign step     = en & lvl_q;
   assign port_clk = pclk_q;

   // R6: a disabled cycle parks the forwarded clock low
   a_r6_clk_parked: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !port_clk);

   // R5: two enabled cycles in a row with fixed polarity give a toggle
   a_r5_clk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && $past(en, 2) && ($past(inv) == $past(inv, 2)))
      |-> (port_clk != $past(port_clk)));
endmodule

// File: rtl/rxser_hold.sv
// One-entry holding stage in front of the slicer. It picks the word to
// present when an upper-half slot loads.
module rxser_hold #(
   parameter int WORD_W  = 12,
   parameter bit HOLD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [WORD_W-1:0] in_word,
   input  logic              load,
   output logic              cand_vld,
   output logic [WORD_W-1:0] cand_word
);
   generate
      if (HOLD_EN) begin : g_hold
         logic              hv_q;
         logic [WORD_W-1:0] hw_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hv_q <= 1'b0;
               hw_q <= '0;
            end else if (load) begin
               // held word leaves now; a coincident offer takes its place
               if (hv_q) begin
                  hv_q <= in_vld;
                  hw_q <= in_word;
               end
            end else if (in_vld) begin
               hv_q <= 1'b1;
               hw_q <= in_word;
            end
         end

         assign cand_vld  = hv_q | in_vld;
         assign cand_word = hv_q ? hw_q : in_word;

         // R7: an offer outside a load is retained
         a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
            (!load && in_vld) |=> hv_q);

         // R10: a load with nothing new drains the holding register
         a_r10_drain: assert property (@(posedge clk) disable iff (!rst_n)
            (load && hv_q && !in_vld) |=> !hv_q);
      end else begin : g_pass
         assign cand_vld  = in_vld;
         assign cand_word = in_word;
      end
   endgenerate
endmodule

// File: rtl/rxser_slicer.sv
// Word register and nibble output stage, advanced once per step.
module rxser_slicer
   import rxser_pkg::*;
#(
   parameter int                WORD_W     = 12,
   parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  step,
   input  logic                  cand_vld,
   input  logic [WORD_W-1:0]     cand_word,
   output logic                  load,
   output logic [WORD_W/2-1:0]   nib,
   output logic                  sync
);
   localparam int NIB_W = WORD_W / 2;

   slot_e             slot_q;
   logic [WORD_W-1:0] cur_q;
   logic [WORD_W-1:0] nxt_word;
   logic [NIB_W-1:0]  nib_q;
   logic              sync_q;

   assign load     = step && (slot_q == SLOT_LSB);
   assign nxt_word = cand_vld ? cand_word : cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= SLOT_MSB;
         cur_q  <= RESET_WORD;
         nib_q  <= RESET_WORD[WORD_W-1:NIB_W];
         sync_q <= 1'b0;
      end else if (load) begin
         cur_q  <= nxt_word;
         nib_q  <= nxt_word[WORD_W-1:NIB_W];
         sync_q <= 1'b0;
         slot_q <= SLOT_MSB;
      end else if (step) begin
         nib_q  <= cur_q[NIB_W-1:0];
         sync_q <= 1'b1;
         slot_q <= SLOT_LSB;
      end
   end

   assign nib  = nib_q;
   assign sync = sync_q;

   // R2: a load starts an upper-half slot with sync low
   a_r2_msb_sync_low: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !sync_q);

   // R3: the step after an upper half raises sync
   a_r3_lsb_sync_high: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> sync_q);

   // R4: without a step the bus holds still
   a_r4_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(nib_q) && $stable(sync_q)));

   // R8: a load with no candidate keeps the previous word
   a_r8_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !cand_vld) |=> $stable(cur_q));
endmodule

// File: rtl/rx_nibble_serializer.sv
module rx_nibble_serializer #(
   parameter int                WORD_W     = 12,
   parameter bit                HOLD_EN    = 1'b1,
   parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clk_en,
   input  logic                clk_inv,
   input  logic [WORD_W-1:0]   rx_word,
   input  logic                rx_word_vld,
   output logic [WORD_W/2-1:0] nib_out,
   output logic                nib_sync,
   output logic                port_clk
);
   localparam int NIB_W = WORD_W / 2;

   generate
      if ((WORD_W % 2) != 0 || WORD_W < 2) begin : g_bad_width
         $error("rx_nibble_serializer: WORD_W must be even and at least 2");
      end
   endgenerate

   logic              step;
   logic              load;
   logic              cand_vld;
   logic [WORD_W-1:0] cand_word;
   logic [NIB_W-1:0]  nib;

   rxser_clkgen u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (clk_en),
      .inv      (clk_inv),
      .step     (step),
      .port_clk (port_clk)
   );

   rxser_hold #(.WORD_W(WORD_W), .HOLD_EN(HOLD_EN)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vld    (rx_word_vld),
      .in_word   (rx_word),
      .load      (load),
      .cand_vld  (cand_vld),
      .cand_word (cand_word)
   );

   rxser_slicer #(.WORD_W(WORD_W), .RESET_WORD(RESET_WORD)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .cand_vld  (cand_vld),
      .cand_word (cand_word),
      .load      (load),
      .nib       (nib),
      .sync      (nib_sync)
   );

   assign nib_out = nib;
endmodule

// File: tb/tb_rx_nibble_serializer.sv
`timescale 1ns/1ps
module tb_rx_nibble_serializer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clk_en = 1'b0;
   logic        clk_inv = 1'b0;
   logic [11:0] rx_word = '0;
   logic        rx_word_vld = 1'b0;
   logic [5:0]  nib_out;
   logic        nib_sync;
   logic        port_clk;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   rx_nibble_serializer dut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .clk_inv(clk_inv),
      .rx_word(rx_word), .rx_word_vld(rx_word_vld),
      .nib_out(nib_out), .nib_sync(nib_sync), .port_clk(port_clk)
   );

   // {word, upper nibble, lower nibble}
   localparam logic [23:0] VEC [9] = '{
      {12'h000, 6'h00, 6'h00},
      {12'hFFF, 6'h3F, 6'h3F},
      {12'h800, 6'h20, 6'h00},
      {12'h7FF, 6'h1F, 6'h3F},
      {12'hABC, 6'h2A, 6'h3C},
      {12'h041, 6'h01, 6'h01},
      {12'hFC0, 6'h3F, 6'h00},
      {12'h03F, 6'h00, 6'h3F},
      {12'h555, 6'h15, 6'h15}
   };

   // ---------------- port monitor (samples on the falling edge) ----------
   int         cyc = 0;
   logic       act, prev_act = 1'b0;
   logic [5:0] prev_nib = '0;
   logic       prev_sync = 1'b0;
   logic       have_msb = 1'b0;
   logic [5:0] msb_buf = '0;
   int         msb_cyc = 0;
   int         rx_cnt = 0;
   int         cap_cnt = 0;
   logic [5:0] rx_msb = '0, rx_lsb = '0;
   int         rx_cyc = 0;
   logic       last_cap_sync = 1'b0;
   int         r4_viol = 0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      act = port_clk ^ clk_inv;
      if (!rst_n) begin
         have_msb = 1'b0;
      end else begin
         if (!prev_act && act) begin
            if (nib_out != prev_nib || nib_sync != prev_sync) r4_viol++;
            cap_cnt++;
            last_cap_sync = nib_sync;
            if (!nib_sync) begin
               msb_buf  = nib_out;
               msb_cyc  = cyc;
               have_msb = 1'b1;
            end else if (have_msb) begin
               rx_msb   = msb_buf;
               rx_lsb   = nib_out;
               rx_cyc   = msb_cyc;
               rx_cnt++;
               have_msb = 1'b0;
            end
         end
      end
      prev_act  = act;
      prev_nib  = nib_out;
      prev_sync = nib_sync;
   end

   // ---------------- helpers ---------------------------------------------
   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic check(input bit ok, input string req, input int actv, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, actv, expv);
      end
   endtask

   task automatic offer(input logic [11:0] w, output int t);
      rx_word     = w;
      rx_word_vld = 1'b1;
      t           = cyc;
      tick();
      rx_word_vld = 1'b0;
   endtask

   task automatic wait_word(input int t0, output logic [5:0] m, output logic [5:0] l,
                            output bit got);
      int seen;
      seen = rx_cnt;
      got  = 1'b0;
      m    = '0;
      l    = '0;
      for (int k = 0; k < 64 && !got; k++) begin
         tick();
         if (rx_cnt != seen) begin
            seen = rx_cnt;
            if (rx_cyc >= t0 + 2) begin
               m   = rx_msb;
               l   = rx_lsb;
               got = 1'b1;
            end
         end
      end
   endtask

   task automatic expect_word(input int t0, input logic [5:0] em, input logic [5:0] el,
                              input string rm, input string rl);
      logic [5:0] m, l;
      bit got;
      wait_word(t0, m, l, got);
      check(got && m == em, rm, int'(m), int'(em));
      check(got && l == el, rl, int'(l), int'(el));
   endtask

   task automatic align_to_load();
      for (int k = 0; k < 16; k++) begin
         if ((port_clk ^ clk_inv) && nib_sync) return;
         tick();
      end
   endtask

   task automatic do_reset(input logic inv);
      rst_n       = 1'b0;
      clk_en      = 1'b0;
      clk_inv     = inv;
      rx_word_vld = 1'b0;
      repeat (4) tick();
      check(nib_out == 6'h00 && nib_sync == 1'b0 && port_clk == 1'b0, "R1",
            int'({nib_out, nib_sync, port_clk}), 0);
      rst_n = 1'b1;
      tick();
      clk_en = 1'b1;
   endtask

   task automatic check_pol();
      logic s0;
      s0 = nib_sync;
      for (int k = 0; k < 8 && nib_sync == s0; k++) tick();
      check(port_clk == clk_inv, "R5 polarity at bus change", int'(port_clk), int'(clk_inv));
   endtask

   // ---------------- watchdog --------------------------------------------
   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   // ---------------- main sequence ---------------------------------------
   initial begin
      int t, ta, tb2, tc, td, te, cc;
      logic p, s, ss;
      logic [5:0] sn;
      bit ok;

      // R1, R9: reset state and zero word before any input
      do_reset(1'b0);
      expect_word(cyc - 2, 6'h00, 6'h00, "R9 msb", "R9 lsb");

      // R5: forwarded clock toggles each enabled cycle
      tick();
      p  = port_clk;
      ok = 1'b1;
      for (int k = 0; k < 6; k++) begin
         tick();
         if (port_clk == p) ok = 1'b0;
         p = port_clk;
      end
      check(ok, "R5 toggle", int'(ok), 1);
      check_pol();

      // R2/R3: table of words at varying offer phases
      for (int i = 0; i < 9; i++) begin
         repeat (i % 3) tick();
         offer(VEC[i][23:12], t);
         expect_word(t, VEC[i][11:6], VEC[i][5:0], "R2", "R3");
      end

      // R8: no new word, last word repeats
      expect_word(cyc, 6'h15, 6'h15, "R8 msb", "R8 lsb");
      expect_word(cyc, 6'h15, 6'h15, "R8 msb", "R8 lsb");

      // R10: direct load, upper half seen two cycles after the offer
      align_to_load();
      offer(12'h123, t);
      expect_word(t, 6'h04, 6'h23, "R10 direct msb", "R10 direct lsb");
      check(rx_cyc == t + 2, "R10 latency", rx_cyc - t, 2);

      // R10: held word goes out before a word offered at the load
      align_to_load();
      tick();
      offer(12'hC35, ta);
      align_to_load();
      offer(12'h3CA, tb2);
      expect_word(ta, 6'h30, 6'h35, "R10 held first msb", "R10 held first lsb");
      expect_word(tb2, 6'h0F, 6'h0A, "R10 then new msb", "R10 then new lsb");

      // R7: two offers before a load, only the latest survives
      align_to_load();
      tick();
      offer(12'h111, tc);
      offer(12'h2E7, td);
      expect_word(tc, 6'h0B, 6'h27, "R7 overwrite msb", "R7 overwrite lsb");
      expect_word(cyc, 6'h0B, 6'h27, "R8 repeat msb", "R8 repeat lsb");

      // R6: disable parks the clock and freezes the bus; R7 capture while off
      repeat (3) tick();
      cc     = cap_cnt;
      s      = last_cap_sync;
      clk_en = 1'b0;
      tick();
      sn = nib_out;
      ss = nib_sync;
      ok = 1'b1;
      for (int k = 0; k < 6; k++) begin
         if (port_clk !== 1'b0 || nib_out !== sn || nib_sync !== ss) ok = 1'b0;
         tick();
      end
      offer(12'hE1D, te);
      if (port_clk !== 1'b0 || nib_out !== sn || nib_sync !== ss) ok = 1'b0;
      check(ok, "R6 frozen while disabled", int'(ok), 1);
      check(cap_cnt == cc, "R6 no edges while disabled", cap_cnt - cc, 0);
      clk_en = 1'b1;
      for (int k = 0; k < 16 && cap_cnt == cc; k++) tick();
      check(last_cap_sync != s, "R6 sequence resumes", int'(last_cap_sync), int'(!s));
      expect_word(te, 6'h38, 6'h1D, "R7 held while off msb", "R7 held while off lsb");

      // Inverted clock run
      do_reset(1'b1);
      check_pol();
      for (int i = 0; i < 5; i++) begin
         repeat ((i + 1) % 3) tick();
         offer(VEC[i + 4][23:12], t);
         expect_word(t, VEC[i + 4][11:6], VEC[i + 4][5:0], "R2 inverted", "R3 inverted");
      end

      // R4: no bus change ever seen at an active edge
      check(r4_viol == 0, "R4", r4_viol, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule